// File: doc/BRIEF.md
# Countdown Event Timer

This block is a single down-counting event timer with a small register window and one level interrupt line. Software enables the timer, writes a tick count into the value register, and the count begins falling by one on every following clock. When it reaches zero the timer raises a pending flag, stops at zero, and drives the interrupt whenever interrupt delivery is enabled.

One enable bit in the control register governs every change of state. While it is clear, the count stays frozen, writes to the value register are dropped, and a request to clear the pending flag does nothing. A normal arming sequence therefore sets the enable bit first and then writes the tick count. Clearing the pending flag is a write-action bit that is not stored.

Top module: `evt_timer`

## Requirements
- R1: After a synchronous reset, irq_o is 0, the control register reads 0 and the value register reads 0.
- R2: The control register is at byte offset 0x40. Bit 0 is enable, bit 1 is interrupt enable, bit 2 is the read-only pending flag, and bit 4 is a clear request that always reads 0. The value register is at offset 0x44. Any other offset reads 0. reg_rdata is registered: it shows the state of the cycle in which reg_addr was presented, one clock later.
- R3: A write to the value register while the stored enable bit is 0 has no effect on the count.
- R4: A value write while enabled places the written value in the count at that clock edge. The count then falls by one on each later edge while enabled, and reading the value register returns the remaining count.
- R5: The full 32-bit range of tick counts is accepted, including the maximum 0xFFFFFFFF. The intended minimum is 3.
- R6: When value V is loaded at edge W, the pending flag sets at edge W+V, as the count goes from 1 to 0. The count then holds at 0 until it is reloaded.
- R7: irq_o is a registered level equal to pending AND interrupt enable. It changes at the same edge as either of those two bits.
- R8: A clear request (bit 4) clears pending only when bit 0 is also 1 in the same control write. Otherwise pending is kept.
- R9: A control write with bit 0 at 0 stops counting, and the count holds its value.
- R10: If a value load and a reach-zero step fall in the same cycle, the load wins and pending is not set in that cycle.
- R11: If a clear request and a reach-zero step fall in the same cycle, the reach-zero step wins and pending ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle: a value load and the final decrement, and a clear request and the final decrement. The bench places the second write on exactly the edge where the count would step from 1 to 0. For the load case, it judges the result by irq_o staying low and by the new count reading back, followed by a fresh timeout at the expected edge. For the clear case, it judges the result by irq_o staying high. Around these cases, a sweep over load values checks the arrival edge of the timeout for each value.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned IE_BIT   = 1;
  localparam int unsigned PEND_BIT = 2;
  localparam int unsigned CLR_BIT  = 4;

  typedef struct packed {
    logic en;
    logic ie;
    logic pend;
  } ctrl_state_t;
endpackage

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_n;

  assign hit = en && !load && (cnt == ONE);

  always_comb begin
    cnt_n = cnt;
    if (load)
      cnt_n = load_val;
    else if (en && (cnt != '0))
      cnt_n = cnt - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_n;
  end

  // R9
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(cnt));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
  // R6
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt == '0) && !load) |=> (cnt == '0));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_we,
  input  logic        wr_en_bit,
  input  logic        wr_ie_bit,
  input  logic        wr_clr_bit,
  input  logic        hit,
  output ctrl_state_t st,
  output logic        irq_o
);
  ctrl_state_t st_n;

  always_comb begin
    st_n = st;
    if (ctrl_we) begin
      st_n.en = wr_en_bit;
      st_n.ie = wr_ie_bit;
    end
    if (hit)
      st_n.pend = 1'b1;
    else if (ctrl_we && wr_clr_bit && wr_en_bit)
      st_n.pend = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      irq_o <= 1'b0;
    end else begin
      st    <= st_n;
      irq_o <= st_n.pend && st_n.ie;
    end
  end

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st.pend) |-> $past(ctrl_we && wr_clr_bit && wr_en_bit));
  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (st.pend && st.ie));
  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> st.pend);
endmodule

// File: rtl/evt_timer_rdmux.sv
module evt_timer_rdmux
  import evt_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CTRL_OFS = 'h40,
  parameter int unsigned VAL_OFS  = 'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_state_t       st,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(VAL_OFS);

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_n;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[EN_BIT]   = st.en;
    ctrl_word[IE_BIT]   = st.ie;
    ctrl_word[PEND_BIT] = st.pend;
  end

  always_comb begin
    rd_n = '0;
    if (addr == A_CTRL)     rd_n = ctrl_word;
    else if (addr == A_VAL) rd_n = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  // R2
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CTRL) |=> (rdata[CLR_BIT] == 1'b0));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CTRL_OFS = 'h40,
  parameter int unsigned VAL_OFS  = 'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(VAL_OFS);

  ctrl_state_t       st;
  logic [DATA_W-1:0] cnt;
  logic              hit;
  logic              ctrl_we;
  logic              val_we;
  logic              val_load;

  assign ctrl_we  = reg_we && (reg_addr == A_CTRL);
  assign val_we   = reg_we && (reg_addr == A_VAL);
  assign val_load = val_we && st.en;

  evt_timer_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .wr_en_bit  (reg_wdata[EN_BIT]),
    .wr_ie_bit  (reg_wdata[IE_BIT]),
    .wr_clr_bit (reg_wdata[CLR_BIT]),
    .hit        (hit),
    .st         (st),
    .irq_o      (irq_o)
  );

  evt_timer_count #(.CNT_W(DATA_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .en       (st.en),
    .load     (val_load),
    .load_val (reg_wdata),
    .cnt      (cnt),
    .hit      (hit)
  );

  evt_timer_rdmux #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .VAL_OFS  (VAL_OFS)
  ) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .addr  (reg_addr),
    .st    (st),
    .cnt   (cnt),
    .rdata (reg_rdata)
  );

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st.pend) |-> ($past(cnt) == DATA_W'(1)) && !$past(val_load));
  // R3
  ignore_off_chk: assert property (@(posedge clk) disable iff (rst)
    (val_we && !st.en) |=> $stable(cnt));
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_VAL  = 8'h44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
    rd(A_VAL, v);  chk("R1 value reset", v, 32'h0);
    rd(8'h10, v);  chk("R2 unmapped offset", v, 32'h0);

    // R3: disabled write ignored
    wr(A_VAL, 32'd50);
    wr(A_CTRL, 32'h1);
    rd(A_VAL, v); chk("R3 write while disabled", v, 32'h0);

    // R4 R6 R2 sweep over load values
    for (int n = 3; n <= 34; n++) begin
      wr(A_CTRL, 32'h13);
      chk("R8 clear before arm", {31'h0, irq_o}, 32'h0);
      wr(A_VAL, n);
      rd(A_VAL, v); chk("R4 loaded value", v, n);
      repeat (n - 2) @(posedge clk);
      @(negedge clk);
      chk("R6 no timeout one edge early", {31'h0, irq_o}, 32'h0);
      @(posedge clk); @(negedge clk);
      chk("R6 timeout at W+V", {31'h0, irq_o}, 32'h1);
      rd(A_CTRL, v); chk("R2 ctrl readback pending", v, 32'h7);
      rd(A_VAL, v);  chk("R6 count holds zero", v, 32'h0);
    end

    // R7: interrupt enable gating
    wr(A_CTRL, 32'h11);
    wr(A_VAL, 32'd3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7 masked irq", {31'h0, irq_o}, 32'h0);
    rd(A_CTRL, v); chk("R7 pending while masked", v, 32'h5);
    wr(A_CTRL, 32'h03);
    chk("R7 irq on enable", {31'h0, irq_o}, 32'h1);

    // R8: clear needs enable bit in same write
    wr(A_CTRL, 32'h12);
    chk("R8 clear without enable ignored", {31'h0, irq_o}, 32'h1);
    rd(A_CTRL, v); chk("R8 ctrl after ignored clear", v, 32'h6);
    wr(A_CTRL, 32'h13);
    chk("R8 clear with enable", {31'h0, irq_o}, 32'h0);
    rd(A_CTRL, v); chk("R8 ctrl after clear", v, 32'h3);

    // R9: stop holds count; R3 write while stopped
    wr(A_VAL, 32'd1000);
    repeat (10) @(posedge clk);
    @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_VAL, held); chk("R9 count at stop", held, 32'd989);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(A_VAL, v); chk("R9 count held", v, 32'd989);
    wr(A_VAL, 32'd5);
    rd(A_VAL, v); chk("R3 write while stopped", v, 32'd989);

    // R10: load collides with reach-zero
    wr(A_CTRL, 32'h13);
    wr(A_VAL, 32'd4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr(A_VAL, 32'd6);
    chk("R10 no pending on collision", {31'h0, irq_o}, 32'h0);
    rd(A_VAL, v); chk("R10 new count loaded", v, 32'd6);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 not yet expired", {31'h0, irq_o}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R10 expires after reload", {31'h0, irq_o}, 32'h1);

    // R11: clear collides with reach-zero
    wr(A_CTRL, 32'h13);
    wr(A_VAL, 32'd3);
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr(A_CTRL, 32'h13);
    chk("R11 set wins over clear", {31'h0, irq_o}, 32'h1);
    wr(A_CTRL, 32'h13);
    chk("R11 later clear works", {31'h0, irq_o}, 32'h0);

    // R5: maximum value
    wr(A_VAL, 32'hFFFF_FFFF);
    rd(A_VAL, v); chk("R5 max value", v, 32'hFFFF_FFFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule